// File: doc/BRIEF.md
# Column Hit Time-Stamper with Shared Line TDCs

This block terminates one 45-pixel detector column. Pixels deliver hits as time-over-threshold pulses on nine shared hit lines, with five pixels sharing each line. A separate five-line address bus shows which of those five pixels is firing. For each line the block watches for the rising and the falling edge of the pulse. On each edge it stores the coarse clock count and the 32-tap delay-line state present in that clock cycle.

A single shared encoder turns the tap state into a 5-bit fine code. Before encoding, it removes isolated bubbles with a three-tap majority vote. The pixel number is formed from the line index and the set address bit. A pixel number that cannot be resolved uniquely is flagged rather than dropped.

Finished records wait in a small per-line queue. A merge stage with fixed priority hands them out on a valid/ready stream. The back-pressure rules are these:
- Once `out_valid` is high, the record stays unchanged until a cycle in which `out_ready` is high.
- A record is taken on every clock edge at which both `out_valid` and `out_ready` are high.
- While the stream is stalled, a line whose queue is full drops new pulses and counts them as lost.

Offline software uses the leading/trailing pair to correct time-walk from the pulse width.

Top module: `col_hit_stamper`

## Requirements
- R1: After reset, `out_valid` is 0 and `lost_count` is 0.
- R2: For a pulse on hit line L (0..8) with exactly one address bit b (0..4) set at the leading edge, the record reports pixel = 5*L + b and `out_ambig` = 0.
- R3: The leading fine/coarse fields come from `tap_state`/`coarse_now` in the clock where the line is first sampled high. The trailing fields come from the clock where the line is first sampled low again.
- R4: Bit i of the tap vector t is filtered as f[i] = majority(t[i-1], t[i], t[i+1]), with t[-1] taken as 1 and t[32] taken as 0. The fine code is the lowest k with f[k]=1 and f[k+1]=0. If no such k exists, the code is 31 when f[0]=1 and 0 otherwise.
- R5: If the number of set address bits at the leading edge is not exactly one, `out_ambig` = 1. The pixel then uses the lowest set bit, or bit 0 when none is set.
- R6: If more than one hit line is high in the leading-edge clock, every record started in that clock has `out_ambig` = 1.
- R7: Each line holds up to two finished records. A leading edge on a line whose queue is full is dropped: no record results, and `lost_count` increments by one per dropped edge.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid` and all record fields stay unchanged.
- R9: When several lines hold records, the lowest line index is delivered first. Records from one line come out in arrival order.
- R10: With the output stage empty, a record is valid after the second clock edge counted from the trailing-edge sample (that edge included).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_line | input | 9 | Time-over-threshold pulses, one per shared line (already synchronous) |
| addr_line | input | 5 | One-hot position of the firing pixel within its line |
| tap_state | input | 32 | Delay-line tap snapshot, thermometer-coded |
| coarse_now | input | 6 | Coarse clock count |
| out_ready | input | 1 | Consumer can take a record |
| out_valid | output | 1 | Record available |
| out_pixel | output | 6 | Pixel number 0..44 |
| out_ambig | output | 1 | Pixel identity not unique |
| out_lead_fine | output | 5 | Fine code of the leading edge |
| out_lead_coarse | output | 6 | Coarse count of the leading edge |
| out_trail_fine | output | 5 | Fine code of the trailing edge |
| out_trail_coarse | output | 6 | Coarse count of the trailing edge |
| lost_count | output | 8 | Saturating count of dropped leading edges |

## Verification
The assertions assume three things about the inputs:
- `hit_line`, `addr_line`, `tap_state` and `coarse_now` are synchronous to `clk`.
- The address bus is held steady through the clock in which a line rises.
- The consumer honours the stall rule on its own side.

The stimulus meets these assumptions by changing every input only on the falling clock edge, and by holding address and taps for a full cycle around each edge. It also raises `out_ready` only for single cycles while a record is visible.

// File: rtl/eoc_tdc_pkg.sv
package eoc_tdc_pkg;
  localparam int N_LINES      = 9;
  localparam int PIX_PER_LINE = 5;
  localparam int N_TAPS       = 32;
  localparam int COARSE_W     = 6;
  localparam int FINE_W       = $clog2(N_TAPS);
  localparam int N_PIX        = N_LINES * PIX_PER_LINE;
  localparam int PIX_W        = $clog2(N_PIX);
  localparam int IDX_W        = $clog2(PIX_PER_LINE);

  typedef struct packed {
    logic [PIX_W-1:0]    pixel;
    logic                ambig;
    logic [COARSE_W-1:0] lead_coarse;
    logic [FINE_W-1:0]   lead_fine;
    logic [COARSE_W-1:0] trail_coarse;
    logic [FINE_W-1:0]   trail_fine;
  } hit_rec_t;
endpackage

// File: rtl/thermo_enc.sv
module thermo_enc #(
  parameter int N_TAPS = 32,
  parameter int FINE_W = $clog2(N_TAPS)
) (
  input  logic [N_TAPS-1:0] taps,
  output logic [FINE_W-1:0] code
);
  // Extended vector: below tap 0 counts as 1, above the last tap as 0.
  logic [N_TAPS+1:0] ext;
  logic [N_TAPS-1:0] filt;

  assign ext = {1'b0, taps, 1'b1};

  for (genvar i = 0; i < N_TAPS; i++) begin : g_vote
    assign filt[i] = (ext[i] & ext[i+1]) | (ext[i+1] & ext[i+2]) | (ext[i] & ext[i+2]);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    code  = '0;
    for (int k = 0; k < N_TAPS - 1; k++) begin
      if (!found && filt[k] && !filt[k+1]) begin
        code  = FINE_W'(k);
        found = 1'b1;
      end
    end
    if (!found) code = filt[0] ? FINE_W'(N_TAPS - 1) : '0;
  end
endmodule

// File: rtl/line_tdc.sv
module line_tdc
  import eoc_tdc_pkg::*;
#(
  parameter int LINE_IDX = 0,
  parameter int DEPTH    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hit_in,
  input  logic                    multi_line,
  input  logic [PIX_PER_LINE-1:0] addr_bus,
  input  logic [FINE_W-1:0]       fine_now,
  input  logic [COARSE_W-1:0]     coarse_now,
  input  logic                    pop,
  output hit_rec_t                head,
  output logic                    nonempty,
  output logic                    lost_pulse
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                hit_q, busy;
  logic [PIX_W-1:0]    pend_pixel;
  logic                pend_ambig;
  logic [COARSE_W-1:0] pend_coarse;
  logic [FINE_W-1:0]   pend_fine;

  logic [IDX_W-1:0]    sel_idx;
  logic                addr_bad, lead_ev, trail_ev, full;
  hit_rec_t            new_rec;

  hit_rec_t            mem [DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0]    count;

  always_comb begin
    sel_idx = '0;
    for (int b = PIX_PER_LINE - 1; b >= 0; b--)
      if (addr_bus[b]) sel_idx = IDX_W'(b);
  end

  assign addr_bad   = ($countones(addr_bus) != 1);
  assign lead_ev    = hit_in & ~hit_q;
  assign trail_ev   = ~hit_in & hit_q & busy;
  assign full       = (count == CNT_W'(DEPTH));
  assign lost_pulse = lead_ev & full;

  always_comb begin
    new_rec.pixel        = pend_pixel;
    new_rec.ambig        = pend_ambig;
    new_rec.lead_coarse  = pend_coarse;
    new_rec.lead_fine    = pend_fine;
    new_rec.trail_coarse = coarse_now;
    new_rec.trail_fine   = fine_now;
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q       <= 1'b0;
      busy        <= 1'b0;
      pend_pixel  <= '0;
      pend_ambig  <= 1'b0;
      pend_coarse <= '0;
      pend_fine   <= '0;
    end else begin
      hit_q <= hit_in;
      if (lead_ev && !full) begin
        busy        <= 1'b1;
        pend_pixel  <= PIX_W'(LINE_IDX * PIX_PER_LINE) + PIX_W'(sel_idx);
        pend_ambig  <= addr_bad | multi_line;
        pend_coarse <= coarse_now;
        pend_fine   <= fine_now;
      end else if (trail_ev) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (trail_ev) wr_ptr <= bump(wr_ptr);
      if (pop)      rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(trail_ev) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (trail_ev) mem[wr_ptr] <= new_rec;
  end

  assign head     = mem[rd_ptr];
  assign nonempty = (count != '0);
endmodule

// File: rtl/rec_merge.sv
module rec_merge
  import eoc_tdc_pkg::*;
#(
  parameter int N = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  hit_rec_t [N-1:0]   heads,
  input  logic [N-1:0]       nonempty,
  input  logic               out_ready,
  output logic [N-1:0]       pop,
  output logic               out_valid,
  output hit_rec_t           out_rec
);
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

  logic [SEL_W-1:0] pick;
  logic             any, load;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (nonempty[i]) begin
        pick = SEL_W'(i);
        any  = 1'b1;
      end
    end
  end

  assign load = any & (~out_valid | out_ready);

  always_comb begin
    for (int i = 0; i < N; i++) pop[i] = load && (pick == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rec   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_rec   <= heads[pick];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/col_hit_stamper.sv
module col_hit_stamper
  import eoc_tdc_pkg::*;
#(
  parameter int LOST_W     = 8,
  parameter int LINE_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_LINES-1:0]      hit_line,
  input  logic [PIX_PER_LINE-1:0] addr_line,
  input  logic [N_TAPS-1:0]       tap_state,
  input  logic [COARSE_W-1:0]     coarse_now,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [PIX_W-1:0]        out_pixel,
  output logic                    out_ambig,
  output logic [FINE_W-1:0]       out_lead_fine,
  output logic [COARSE_W-1:0]     out_lead_coarse,
  output logic [FINE_W-1:0]       out_trail_fine,
  output logic [COARSE_W-1:0]     out_trail_coarse,
  output logic [LOST_W-1:0]       lost_count
);
  localparam int LN_W = $clog2(N_LINES + 1);

  logic [FINE_W-1:0]  fine_now;
  logic               multi_line;
  hit_rec_t [N_LINES-1:0] heads;
  logic [N_LINES-1:0] nonempty, pop, lost_vec;
  hit_rec_t           out_rec;
  logic [LN_W-1:0]    lost_n;
  logic [LOST_W:0]    lost_sum;

  thermo_enc #(.N_TAPS(N_TAPS), .FINE_W(FINE_W)) u_enc (
    .taps (tap_state),
    .code (fine_now)
  );

  assign multi_line = ($countones(hit_line) > 1);

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    line_tdc #(.LINE_IDX(l), .DEPTH(LINE_DEPTH)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_in     (hit_line[l]),
      .multi_line (multi_line),
      .addr_bus   (addr_line),
      .fine_now   (fine_now),
      .coarse_now (coarse_now),
      .pop        (pop[l]),
      .head       (heads[l]),
      .nonempty   (nonempty[l]),
      .lost_pulse (lost_vec[l])
    );
  end

  rec_merge #(.N(N_LINES)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .heads     (heads),
    .nonempty  (nonempty),
    .out_ready (out_ready),
    .pop       (pop),
    .out_valid (out_valid),
    .out_rec   (out_rec)
  );

  assign lost_n   = LN_W'($countones(lost_vec));
  assign lost_sum = {1'b0, lost_count} + (LOST_W + 1)'(lost_n);

  always_ff @(posedge clk) begin
    if (!rst_n)                lost_count <= '0;
    else if (lost_sum[LOST_W]) lost_count <= '1;
    else                       lost_count <= lost_sum[LOST_W-1:0];
  end

  assign out_pixel        = out_rec.pixel;
  assign out_ambig        = out_rec.ambig;
  assign out_lead_fine    = out_rec.lead_fine;
  assign out_lead_coarse  = out_rec.lead_coarse;
  assign out_trail_fine   = out_rec.trail_fine;
  assign out_trail_coarse = out_rec.trail_coarse;
endmodule

// File: rtl/col_hit_stamper_chk.sv
module col_hit_stamper_chk
  import eoc_tdc_pkg::*;
#(
  parameter int LOST_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_TAPS-1:0]   tap_state,
  input logic [FINE_W-1:0]   fine_now,
  input logic                out_ready,
  input logic                out_valid,
  input logic [PIX_W-1:0]    out_pixel,
  input logic                out_ambig,
  input logic [FINE_W-1:0]   out_lead_fine,
  input logic [COARSE_W-1:0] out_lead_coarse,
  input logic [FINE_W-1:0]   out_trail_fine,
  input logic [COARSE_W-1:0] out_trail_coarse,
  input logic [LOST_W-1:0]   lost_count
);
  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid && lost_count == '0); // R1

  AST_PIXEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pixel < PIX_W'(N_PIX)); // R2

  AST_ENC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_state == '1) |-> fine_now == FINE_W'(N_TAPS - 1)); // R4

  AST_ENC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_state == '0) |-> fine_now == '0); // R4

  AST_LOST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lost_count >= $past(lost_count)); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel) && $stable(out_ambig)
      && $stable(out_lead_fine) && $stable(out_lead_coarse)
      && $stable(out_trail_fine) && $stable(out_trail_coarse)); // R8
endmodule

bind col_hit_stamper col_hit_stamper_chk #(.LOST_W(LOST_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .tap_state        (tap_state),
  .fine_now         (fine_now),
  .out_ready        (out_ready),
  .out_valid        (out_valid),
  .out_pixel        (out_pixel),
  .out_ambig        (out_ambig),
  .out_lead_fine    (out_lead_fine),
  .out_lead_coarse  (out_lead_coarse),
  .out_trail_fine   (out_trail_fine),
  .out_trail_coarse (out_trail_coarse),
  .lost_count       (lost_count)
);

// File: tb/col_hit_stamper_bench.sv
module col_hit_stamper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  hit_line = '0;
  logic [4:0]  addr_line = '0;
  logic [31:0] tap_state = '0;
  logic [5:0]  coarse_now = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, out_ambig;
  logic [5:0]  out_pixel, out_lead_coarse, out_trail_coarse;
  logic [4:0]  out_lead_fine, out_trail_fine;
  logic [7:0]  lost_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  col_hit_stamper u_col_hit_stamper (
    .clk(clk), .rst_n(rst_n), .hit_line(hit_line), .addr_line(addr_line),
    .tap_state(tap_state), .coarse_now(coarse_now), .out_ready(out_ready),
    .out_valid(out_valid), .out_pixel(out_pixel), .out_ambig(out_ambig),
    .out_lead_fine(out_lead_fine), .out_lead_coarse(out_lead_coarse),
    .out_trail_fine(out_trail_fine), .out_trail_coarse(out_trail_coarse),
    .lost_count(lost_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] therm(input int n);
    return 32'((64'd1 << (n + 1)) - 64'd1);
  endfunction

  // One pulse on the lines in mask: high for one sample, then low.
  task automatic pulse(input logic [8:0] mask, input logic [4:0] addr,
                       input logic [31:0] lt, input logic [5:0] lc,
                       input logic [31:0] tt, input logic [5:0] tc);
    @(negedge clk);
    hit_line = mask; addr_line = addr; tap_state = lt; coarse_now = lc;
    @(negedge clk);
    hit_line = '0; addr_line = '0; tap_state = tt; coarse_now = tc;
    @(negedge clk);
    tap_state = '0; coarse_now = '0;
  endtask

  // Wait for a record, compare it, then accept it.
  task automatic take(input string req, input int pix, input int amb,
                      input int lf, input int lc, input int tf, input int tc);
    int w = 0;
    while (!out_valid && w < 20) begin @(negedge clk); w++; end
    check({req, " valid"}, out_valid, 1);
    check({req, " pixel"}, out_pixel, pix);
    check({req, " ambig"}, out_ambig, amb);
    check({req, " lead fine"}, out_lead_fine, lf);
    check({req, " lead coarse"}, out_lead_coarse, lc);
    check({req, " trail fine"}, out_trail_fine, tf);
    check({req, " trail coarse"}, out_trail_coarse, tc);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 out_valid", out_valid, 0);
    check("R1 lost_count", lost_count, 0);
  endtask

  task automatic t_pixels;
    pulse(9'b000000001, 5'b00001, therm(7), 6'd3, therm(20), 6'd5);
    take("R2 R3 line0", 0, 0, 7, 3, 20, 5);
    pulse(9'b000010000, 5'b00100, therm(0), 6'd40, therm(30), 6'd41);
    take("R2 R3 line4", 22, 0, 0, 40, 30, 41);
    pulse(9'b100000000, 5'b10000, therm(15), 6'd63, therm(2), 6'd0);
    take("R2 R3 line8", 44, 0, 15, 63, 2, 0);
  endtask

  task automatic t_encode;
    // bubble at bit 5 inside run 0..12 -> 12; stray spike at bit 20 -> removed
    pulse(9'b000100000, 5'b00010, therm(12) & ~32'h20, 6'd9,
          therm(3) | 32'h0010_0000, 6'd10);
    take("R4 bubbles", 26, 0, 12, 9, 3, 10);
    pulse(9'b000100000, 5'b00010, 32'hFFFF_FFFF, 6'd11, 32'h0, 6'd12);
    take("R4 extremes", 26, 0, 31, 11, 0, 12);
  endtask

  task automatic t_latency;
    @(negedge clk);
    hit_line = 9'b000000100; addr_line = 5'b01000; tap_state = therm(4); coarse_now = 6'd1;
    @(negedge clk);
    hit_line = '0; addr_line = '0; tap_state = therm(6); coarse_now = 6'd2;
    @(negedge clk); // trailing edge sampled
    tap_state = '0;
    check("R10 not yet valid", out_valid, 0);
    @(negedge clk); // second edge passed
    check("R10 valid", out_valid, 1);
    take("R10 record", 13, 0, 4, 1, 6, 2);
  endtask

  task automatic t_ambig_addr;
    pulse(9'b000001000, 5'b01010, therm(1), 6'd4, therm(2), 6'd6);
    take("R5 two addr bits", 16, 1, 1, 4, 2, 6);
    pulse(9'b000000001, 5'b00000, therm(9), 6'd7, therm(10), 6'd8);
    take("R5 no addr bit", 0, 1, 9, 7, 10, 8);
  endtask

  task automatic t_multi_line_prio;
    pulse(9'b001000010, 5'b00100, therm(5), 6'd20, therm(8), 6'd21);
    take("R6 R9 first line1", 7, 1, 5, 20, 8, 21);
    take("R6 R9 then line6", 32, 1, 5, 20, 8, 21);
  endtask

  task automatic t_lost_stall;
    logic [5:0] p0;
    pulse(9'b000000100, 5'b00001, therm(1), 6'd1, therm(2), 6'd2);
    pulse(9'b000000100, 5'b00001, therm(3), 6'd3, therm(4), 6'd4);
    pulse(9'b000000100, 5'b00001, therm(5), 6'd5, therm(6), 6'd6);
    pulse(9'b000000100, 5'b00001, therm(7), 6'd7, therm(8), 6'd8);
    check("R7 lost_count", lost_count, 1);
    p0 = out_lead_coarse;
    repeat (4) @(negedge clk);
    check("R8 stalled valid", out_valid, 1);
    check("R8 stalled field", out_lead_coarse, p0);
    take("R7 R9 order 1", 10, 0, 1, 1, 2, 2);
    take("R7 R9 order 2", 10, 0, 3, 3, 4, 4);
    take("R7 R9 order 3", 10, 0, 5, 5, 6, 6);
    repeat (4) @(negedge clk);
    check("R7 dropped pulse gives no record", out_valid, 0);
    check("R7 lost_count final", lost_count, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pixels();
    t_encode();
    t_latency();
    t_ambig_addr();
    t_multi_line_prio();
    t_lost_stall();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule